// File: doc/BRIEF.md
# Raster Operation Pixel Combiner

This block merges one source pixel with one destination pixel under an 8-bit raster operation code and returns the new destination value. It sits in the datapath of a 2D block-transfer engine, between the pixel fetch stage and the write-back stage. The pixel fetch and the addressing lie outside this block.

Each code is read as a three-input truth table over a pattern operand, a source operand and the destination. In source mode the two operands are one pixel. In pattern mode the operand is the pattern pixel, and a third input carries the plain source pixel. That third input is used only by the three-operand select code.

A 2-bit format input picks 8, 15 or 16 bits per pixel. In 15-bit mode the spare top bit of the destination is carried through unchanged. A code that the selected mode does not accept leaves the destination untouched and raises a flag. Inputs are taken at a clock edge, and the result appears on registered outputs one cycle later.

Top module: `rop_combiner`

## Requirements
- R1: With `pat_mode`=0, these codes are accepted (`bad_code`=0), where S=`src_px` and D=`dst_px`:
  - 0x00: all zeros
  - 0xFF: all ones
  - 0xCC: S
  - 0xAA: D
  - 0x33: ~S
  - 0x55: ~D
  - 0x88: S&D
  - 0xEE: S|D
  - 0x66: S^D
  - 0x11: ~(S|D)
  - 0x77: ~(S&D)
  - 0x99: ~(S^D)
  - 0x44: S&~D
  - 0x22: D&~S
  - 0xDD: S|~D
  - 0xBB: D|~S
- R2: With `pat_mode`=1 the same sixteen functions are accepted, with P=`src_px` as the operand:
  - 0x00: zeros
  - 0xFF: ones
  - 0xF0: P
  - 0xAA: D
  - 0x0F: ~P
  - 0x55: ~D
  - 0xA0: P&D
  - 0xFA: P|D
  - 0x5A: P^D
  - 0x05: ~(P|D)
  - 0x5F: ~(P&D)
  - 0xA5: ~(P^D)
  - 0x50: P&~D
  - 0x0A: D&~P
  - 0xF5: P|~D
  - 0xAF: D|~P
- R3: With `pat_mode`=1, code 0xB8 gives ((P^D)&N)^P, where N=`sel_px`. Each result bit is the D bit where the N bit is 1, and the P bit where it is 0.
- R4: Every other code/mode pair is unsupported. This includes 0xB8 with `pat_mode`=0 and 0xCC with `pat_mode`=1. For such a pair `bad_code`=1 and the result is `dst_px`, after the format rules of R5 to R7.
- R5: With `pix_fmt`=0 (8 bpp), `result_px[15:8]` is zero and `result_px[7:0]` depends only on the low bytes of the inputs.
- R6: With `pix_fmt`=1 (15 bpp), `result_px[14:0]` is the operation result and `result_px[15]` equals `dst_px[15]`.
- R7: With `pix_fmt`=2 (16 bpp) all 16 result bits come from the operation. `pix_fmt`=3 behaves the same as 2.
- R8: `sel_px` has no effect on the output for any code other than pattern-mode 0xB8.
- R9: The outputs change one clock after the inputs are sampled. A synchronous `rst` clears `result_px` and `bad_code` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_px | input | 16 | Source pixel, or pattern pixel in pattern mode |
| dst_px | input | 16 | Current destination pixel |
| sel_px | input | 16 | Plain source pixel, used by the three-operand select |
| rop_code | input | 8 | Raster operation code |
| pat_mode | input | 1 | 0 selects the source code set, 1 selects the pattern code set |
| pix_fmt | input | 2 | 0: 8 bpp, 1: 15 bpp, 2 or 3: 16 bpp |
| result_px | output | 16 | New destination pixel, registered |
| bad_code | output | 1 | Code not accepted in the selected mode, registered |

## Verification
The assertions assume that every input is driven to known 0/1 values on each clock edge where reset is low. They also assume that an input value pairs with the output one edge later, with no stall or hold in between.

The stimulus respects both assumptions. It changes inputs only on the falling edge, one vector per cycle, and never leaves a vector undriven. It sweeps all 256 codes in both modes and all four format values, and uses fresh random pixel data on every sweep. This lets the select, pass-through and top-bit properties see both polarities of each bit.

// File: rtl/rop_pkg.sv
package rop_pkg;

    localparam int CODE_W = 8;

    typedef enum logic [1:0] {
        PF_8   = 2'd0,
        PF_15  = 2'd1,
        PF_16  = 2'd2,
        PF_16X = 2'd3
    } pix_fmt_e;

    typedef enum logic [1:0] {
        OPK_NONE = 2'd0,
        OPK_SRC  = 2'd1,
        OPK_PAT  = 2'd2,
        OPK_SEL  = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e            kind;
        logic [CODE_W-1:0]   tbl;
    } op_dec_t;

    localparam logic [CODE_W-1:0] CODE_SELECT = 8'hB8;

    // Two-operand source code: the pattern operand plays no part, so both nibbles match.
    function automatic logic is_src_code(input logic [CODE_W-1:0] c);
        return c[7:4] == c[3:0];
    endfunction

    // Two-operand pattern code: the source operand plays no part.
    function automatic logic is_pat_code(input logic [CODE_W-1:0] c);
        return (c[3:2] == c[1:0]) && (c[7:6] == c[5:4]);
    endfunction

endpackage

// File: rtl/rop_code_decoder.sv
module rop_code_decoder
    import rop_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              pat_mode,
    output op_dec_t           dec
);
    always_comb begin
        dec.tbl  = code;
        dec.kind = OPK_NONE;
        if (!pat_mode) begin
            if (is_src_code(code))
                dec.kind = OPK_SRC;
        end else begin
            if (code == CODE_SELECT)
                dec.kind = OPK_SEL;
            else if (is_pat_code(code))
                dec.kind = OPK_PAT;
        end
    end
endmodule

// File: rtl/rop_logic_array.sv
module rop_logic_array
    import rop_pkg::*;
#(
    parameter int PIX_W = 16
) (
    input  op_dec_t          dec,
    input  logic [PIX_W-1:0] src_px,
    input  logic [PIX_W-1:0] dst_px,
    input  logic [PIX_W-1:0] sel_px,
    output logic [PIX_W-1:0] raw_px
);
    // In source mode the operand fills both the pattern and source slots of the table.
    logic use_sel;
    assign use_sel = (dec.kind == OPK_SEL) || (dec.kind == OPK_PAT);

    for (genvar i = 0; i < PIX_W; i++) begin : g_lane
        logic [2:0] idx;
        logic       s_bit;
        always_comb begin
            s_bit = use_sel ? sel_px[i] : src_px[i];
            idx   = {src_px[i], s_bit, dst_px[i]};
            if (dec.kind == OPK_NONE)
                raw_px[i] = dst_px[i];
            else
                raw_px[i] = dec.tbl[idx];
        end
    end
endmodule

// File: rtl/rop_fmt_shaper.sv
module rop_fmt_shaper
    import rop_pkg::*;
#(
    parameter int PIX_W = 16
) (
    input  pix_fmt_e         fmt,
    input  logic [PIX_W-1:0] raw_px,
    input  logic [PIX_W-1:0] dst_px,
    output logic [PIX_W-1:0] out_px
);
    localparam int LOW_W = PIX_W / 2;
    localparam int TOP   = PIX_W - 1;

    always_comb begin
        unique case (fmt)
            PF_8:    out_px = {{(PIX_W-LOW_W){1'b0}}, raw_px[LOW_W-1:0]};
            PF_15:   out_px = {dst_px[TOP], raw_px[TOP-1:0]};
            default: out_px = raw_px;
        endcase
    end
endmodule

// File: rtl/rop_combiner.sv
module rop_combiner
    import rop_pkg::*;
#(
    parameter int PIX_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIX_W-1:0]  src_px,
    input  logic [PIX_W-1:0]  dst_px,
    input  logic [PIX_W-1:0]  sel_px,
    input  logic [CODE_W-1:0] rop_code,
    input  logic              pat_mode,
    input  logic [1:0]        pix_fmt,
    output logic [PIX_W-1:0]  result_px,
    output logic              bad_code
);
    op_dec_t          dec;
    logic [PIX_W-1:0] raw_px;
    logic [PIX_W-1:0] shaped_px;

    rop_code_decoder u_dec (
        .code     (rop_code),
        .pat_mode (pat_mode),
        .dec      (dec)
    );

    rop_logic_array #(.PIX_W(PIX_W)) u_lanes (
        .dec    (dec),
        .src_px (src_px),
        .dst_px (dst_px),
        .sel_px (sel_px),
        .raw_px (raw_px)
    );

    rop_fmt_shaper #(.PIX_W(PIX_W)) u_shape (
        .fmt    (pix_fmt_e'(pix_fmt)),
        .raw_px (raw_px),
        .dst_px (dst_px),
        .out_px (shaped_px)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_px <= '0;
            bad_code  <= 1'b0;
        end else begin
            result_px <= shaped_px;
            bad_code  <= (dec.kind == OPK_NONE);
        end
    end
endmodule

// File: rtl/rop_combiner_chk.sv
module rop_combiner_chk
    import rop_pkg::*;
#(
    parameter int PIX_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [PIX_W-1:0]  src_px,
    input logic [PIX_W-1:0]  dst_px,
    input logic [PIX_W-1:0]  sel_px,
    input logic [CODE_W-1:0] rop_code,
    input logic              pat_mode,
    input logic [1:0]        pix_fmt,
    input logic [PIX_W-1:0]  result_px,
    input logic              bad_code
);
    localparam int LOW_W = PIX_W / 2;

    p_fmt8_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (pix_fmt == 2'd0) |=> (result_px[PIX_W-1:LOW_W] == '0));

    p_fmt15_top_bit_r6: assert property (@(posedge clk) disable iff (rst)
        (pix_fmt == 2'd1) |=> (result_px[PIX_W-1] == $past(dst_px[PIX_W-1])));

    p_src_mode_mixed_nibbles_r4: assert property (@(posedge clk) disable iff (rst)
        (!pat_mode && (rop_code[7:4] != rop_code[3:0])) |=> bad_code);

    p_unsup_keeps_dst_r4: assert property (@(posedge clk) disable iff (rst)
        (bad_code && ($past(pix_fmt) == 2'd2)) |-> (result_px == $past(dst_px)));

    p_copy_src_r1: assert property (@(posedge clk) disable iff (rst)
        (!pat_mode && (rop_code == 8'hCC) && (pix_fmt == 2'd2))
            |=> (!bad_code && (result_px == $past(src_px))));

    p_keep_dst_any_mode_r2: assert property (@(posedge clk) disable iff (rst)
        ((rop_code == 8'hAA) && (pix_fmt == 2'd3))
            |=> (!bad_code && (result_px == $past(dst_px))));

    p_select_b8_r3: assert property (@(posedge clk) disable iff (rst)
        (pat_mode && (rop_code == 8'hB8) && (pix_fmt == 2'd2))
            |=> (result_px == ((($past(src_px) ^ $past(dst_px)) & $past(sel_px)) ^ $past(src_px))));

    p_select_rejected_src_mode_r4: assert property (@(posedge clk) disable iff (rst)
        (!pat_mode && (rop_code == 8'hB8)) |=> bad_code);
endmodule

bind rop_combiner rop_combiner_chk #(.PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_px    (src_px),
    .dst_px    (dst_px),
    .sel_px    (sel_px),
    .rop_code  (rop_code),
    .pat_mode  (pat_mode),
    .pix_fmt   (pix_fmt),
    .result_px (result_px),
    .bad_code  (bad_code)
);

// File: tb/rop_combiner_tb.sv
`timescale 1ns/1ps
module rop_combiner_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src_px = '0, dst_px = '0, sel_px = '0;
    logic [7:0]  rop_code = '0;
    logic        pat_mode = 1'b0;
    logic [1:0]  pix_fmt = '0;
    logic [15:0] result_px;
    logic        bad_code;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        logic [15:0] res;
        logic        bad;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    rop_combiner u_dut (
        .clk(clk), .rst(rst), .src_px(src_px), .dst_px(dst_px), .sel_px(sel_px),
        .rop_code(rop_code), .pat_mode(pat_mode), .pix_fmt(pix_fmt),
        .result_px(result_px), .bad_code(bad_code)
    );

    function automatic logic [15:0] ref_op(input logic [7:0] c, input logic pm,
                                           input logic [15:0] s, input logic [15:0] d,
                                           input logic [15:0] n, output logic bad);
        logic [15:0] r;
        bad = 1'b0;
        r   = d;
        if (!pm) begin
            case (c)
                8'h00: r = 16'h0000;
                8'h11: r = ~(s | d);
                8'h22: r = d & ~s;
                8'h33: r = ~s;
                8'h44: r = s & ~d;
                8'h55: r = ~d;
                8'h66: r = s ^ d;
                8'h77: r = ~(s & d);
                8'h88: r = s & d;
                8'h99: r = ~(s ^ d);
                8'hAA: r = d;
                8'hBB: r = d | ~s;
                8'hCC: r = s;
                8'hDD: r = s | ~d;
                8'hEE: r = s | d;
                8'hFF: r = 16'hFFFF;
                default: bad = 1'b1;
            endcase
        end else begin
            case (c)
                8'h00: r = 16'h0000;
                8'h05: r = ~(s | d);
                8'h0A: r = d & ~s;
                8'h0F: r = ~s;
                8'h50: r = s & ~d;
                8'h55: r = ~d;
                8'h5A: r = s ^ d;
                8'h5F: r = ~(s & d);
                8'hA0: r = s & d;
                8'hA5: r = ~(s ^ d);
                8'hAA: r = d;
                8'hAF: r = d | ~s;
                8'hF0: r = s;
                8'hF5: r = s | ~d;
                8'hFA: r = s | d;
                8'hFF: r = 16'hFFFF;
                8'hB8: r = ((s ^ d) & n) ^ s;
                default: bad = 1'b1;
            endcase
        end
        return r;
    endfunction

    function automatic logic [15:0] shape(input logic [1:0] f, input logic [15:0] r,
                                          input logic [15:0] d);
        case (f)
            2'd0:    return {8'h00, r[7:0]};
            2'd1:    return {d[15], r[14:0]};
            default: return r;
        endcase
    endfunction

    task automatic apply(input logic [7:0] c, input logic pm, input logic [1:0] f,
                         input logic [15:0] s, input logic [15:0] d, input logic [15:0] n,
                         input string force_tag);
        exp_t e;
        logic b;
        logic [15:0] r;
        @(negedge clk);
        rop_code = c; pat_mode = pm; pix_fmt = f;
        src_px = s; dst_px = d; sel_px = n;
        r = ref_op(c, pm, s, d, n, b);
        e.res = shape(f, r, d);
        e.bad = b;
        if (force_tag != "")      e.tag = force_tag;
        else if (b)               e.tag = "R4";
        else if (f == 2'd0)       e.tag = "R5";
        else if (f == 2'd1)       e.tag = "R6";
        else if (f == 2'd3)       e.tag = "R7";
        else if (pm && c == 8'hB8) e.tag = "R3";
        else if (pm)              e.tag = "R2";
        else                      e.tag = "R1";
        sb_q.push_back(e);
    endtask

    // Monitor: each vector pushed at a falling edge is captured at the next rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (result_px !== e.res || bad_code !== e.bad) begin
                    n_fails++;
                    $display("FAIL %s: got result=%h bad=%b, expected result=%h bad=%b",
                             e.tag, result_px, bad_code, e.res, e.bad);
                end
            end
        end
    end

    task automatic check_reset(input string when);
        n_checks++;
        if (result_px !== 16'h0000 || bad_code !== 1'b0) begin
            n_fails++;
            $display("FAIL R9 (%s): got result=%h bad=%b, expected result=0000 bad=0",
                     when, result_px, bad_code);
        end
    endtask

    initial begin
        #(200000 * 8);
        n_fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check_reset("initial");                       // R9 reset state
        @(negedge clk);
        rst = 1'b0;

        // R1, R2, R3, R4, R5, R6, R7: every code, both modes, every format
        for (int fm = 0; fm < 4; fm++) begin
            for (int pm = 0; pm < 2; pm++) begin
                for (int c = 0; c < 256; c++) begin
                    apply(8'(c), 1'(pm), 2'(fm), 16'($urandom), 16'($urandom),
                          16'($urandom), "");
                end
            end
        end

        // R6: bit 15 of dst set and clear under all-ones and all-zeros
        apply(8'hFF, 1'b0, 2'd1, 16'h1234, 16'h0000, 16'h0, "R6");
        apply(8'h00, 1'b0, 2'd1, 16'h1234, 16'h8000, 16'h0, "R6");
        apply(8'h0F, 1'b1, 2'd1, 16'h0000, 16'h7FFF, 16'h0, "R6");
        // R5: upper bytes of the inputs carry noise
        apply(8'hEE, 1'b0, 2'd0, 16'hA501, 16'h5A10, 16'hFFFF, "R5");
        apply(8'hFF, 1'b1, 2'd0, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R5");
        // R3: select with a checkerboard mask
        apply(8'hB8, 1'b1, 2'd2, 16'hF0F0, 16'h0FF0, 16'hAAAA, "R3");
        apply(8'hB8, 1'b1, 2'd2, 16'h0000, 16'hFFFF, 16'h00FF, "R3");
        // R4: select rejected in source mode, source copy rejected in pattern mode
        apply(8'hB8, 1'b0, 2'd2, 16'h1111, 16'hBEEF, 16'hFFFF, "R4");
        apply(8'hCC, 1'b1, 2'd1, 16'h1111, 16'hBEEF, 16'hFFFF, "R4");

        // R8: the same vector with two different sel values must give the same output
        for (int pm = 0; pm < 2; pm++) begin
            for (int c = 0; c < 256; c++) begin
                if (!(pm == 1 && c == 8'hB8)) begin
                    logic [15:0] s, d;
                    s = 16'($urandom);
                    d = 16'($urandom);
                    apply(8'(c), 1'(pm), 2'd2, s, d, 16'h0000, "R8");
                    apply(8'(c), 1'(pm), 2'd2, s, d, 16'hFFFF, "R8");
                end
            end
        end

        // R9: reset in mid-run clears a nonzero output
        apply(8'hFF, 1'b0, 2'd2, 16'h0, 16'h0, 16'h0, "R9");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        check_reset("mid-run");
        @(negedge clk);
        rst = 1'b0;

        wait (sb_q.size() == 0);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule